// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one counting channel of a PC-style programmable interval timer. Software reaches it through a byte-wide register bus with two addresses: a control port and a data port. A control word picks how the 16-bit count is loaded and places the channel in square-wave mode. The count bytes then arrive one at a time through the data port. From that point the channel divides its clock by the count, without stopping, to produce a square wave.

The output rises at the start of every period. A single-cycle interrupt request comes out with each rise and goes to an interrupt controller. A count of 1193182/60 on a 1193182 Hz clock therefore gives 60 requests per second. A latch command takes a snapshot of the running count for a consistent two-byte readback, and the counter keeps running while it is held.

Top module: `pit_channel`

## Requirements
- R1: After reset the output and the interrupt request are low, read data is 0x00, and the channel does not count.
- R2: A control write (bus_addr = 1) is accepted as a mode write only when all of these hold: bits [7:6] equal the channel number (0), bits [5:4] are not 00, bits [3:1] are 011 or 111 (square wave), and bit 0 is 0 (binary). Any other such word is ignored, apart from the latch command in R8. An accepted mode write stops counting, drives the output high, resets both byte toggles and releases any latch.
- R3: Access bits [5:4] = 11 load the count low byte first and then high byte, through the data port (bus_addr = 0). The write of the high byte starts counting in that cycle. A count of 0 stands for 65536. Data writes made before any accepted mode write are ignored.
- R4: Access 01 loads only the low byte and access 10 loads only the high byte. The other byte is zero, and the single write starts counting.
- R5: For a count N ≥ 2, the output is high for ceil(N/2) cycles and low for floor(N/2) cycles, so one period lasts exactly N cycles. The period starts at the loading write's clock edge, and the output is high from that edge on.
- R6: tmr_irq is a one-cycle pulse that comes at each rising edge of the output. The first comes N cycles after the loading edge and the next ones every N cycles after that.
- R7: A count written while the channel is counting takes effect at the next period boundary. The current period is not cut short.
- R8: A control write with bits [7:6] = channel and [5:4] = 00 latches the current count while the counter keeps running. The next two data-port reads return the latched low byte and then the high byte, and the second read releases the latch. A further latch command while one is held is ignored.
- R9: A data-port read with no latch held returns the live count, low and high bytes taken in turn. A control-port read returns 0x00. Read data is registered and appears the cycle after the read.
- R10: With a count of 1 the output stays high and no interrupt request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_addr | input | 1 | 0 = data port, 1 = control port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| tmr_out | output | 1 | Square-wave output |
| tmr_irq | output | 1 | One-cycle interrupt request at each rising output edge |

## Verification
Take K as the clock edge on which the last count byte is written. The output is high from K, falls at K+ceil(N/2), and the request pulses are due at K+N, K+2N and so on. A read is answered one edge after its strobe, with the count as it stood before that edge, which is N minus ((edge-1-K) mod N). The driver notes the edge number at the moment it raises a strobe and pushes each due request cycle or read byte into a queue from that number. The monitor samples at the falling clock edge and matches the edge counter against the head of the queue. Any pulse that comes early, late or unannounced is reported.

// File: rtl/pit_pkg.sv
package pit_pkg;
  // Access field of the control word (bits [5:4]).
  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LOHI  = 2'b11
  } acc_e;

  // Accepted mode field values (bits [3:1]); the top bit is don't-care.
  localparam logic [2:0] MODE_SQW_A = 3'b011;
  localparam logic [2:0] MODE_SQW_B = 3'b111;
endpackage

// File: rtl/pit_cw_decode.sv
module pit_cw_decode
  import pit_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CHAN_ID = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cw_wr,
  input  logic [DW-1:0] wdata,
  output logic          mode_wr,
  output logic          latch_cmd,
  output acc_e          acc
);
  localparam logic [1:0] CH = CHAN_ID[1:0];

  logic chan_hit;
  logic mode_ok;
  acc_e acc_field;

  always_comb begin
    chan_hit  = (wdata[7:6] == CH);
    acc_field = acc_e'(wdata[5:4]);
    mode_ok   = (wdata[3:1] == MODE_SQW_A) || (wdata[3:1] == MODE_SQW_B);
    latch_cmd = cw_wr && chan_hit && (acc_field == ACC_LATCH);
    mode_wr   = cw_wr && chan_hit && (acc_field != ACC_LATCH) && mode_ok && !wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= ACC_LOHI;
    else if (mode_wr) acc <= acc_field;
  end
endmodule

// File: rtl/pit_loader.sv
module pit_loader
  import pit_pkg::*;
#(
  parameter int DW = 8,
  localparam int CNT_W = 2 * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wr,
  input  acc_e             acc,
  input  logic             dat_wr,
  input  logic [DW-1:0]    wdata,
  output logic             load_stb,
  output logic [CNT_W-1:0] load_val
);
  logic          prog_q;
  logic          hi_next_q;
  logic [DW-1:0] lo_q;

  always_comb begin
    load_stb = 1'b0;
    load_val = '0;
    if (dat_wr && prog_q) begin
      unique case (acc)
        ACC_LO:   begin load_stb = 1'b1; load_val = {{DW{1'b0}}, wdata}; end
        ACC_HI:   begin load_stb = 1'b1; load_val = {wdata, {DW{1'b0}}}; end
        ACC_LOHI: begin load_stb = hi_next_q; load_val = {wdata, lo_q}; end
        default:  begin load_stb = 1'b0; load_val = '0; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_q    <= 1'b0;
      hi_next_q <= 1'b0;
      lo_q      <= '0;
    end else if (mode_wr) begin
      prog_q    <= 1'b1;
      hi_next_q <= 1'b0;
    end else if (dat_wr && prog_q && acc == ACC_LOHI) begin
      hi_next_q <= ~hi_next_q;
      if (!hi_next_q) lo_q <= wdata;
    end
  end
endmodule

// File: rtl/pit_sqwave.sv
module pit_sqwave #(
  parameter int CNT_W = 16,
  localparam int EW = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wr,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  output logic             tmr_out,
  output logic             tmr_irq,
  output logic [CNT_W-1:0] cur_cnt
);
  logic          running_q, pend_q, out_q, irq_q;
  logic [EW-1:0] n_q, half_q, cur_q, stage_q;
  logic [EW-1:0] ld_ext, n_nxt, half_nxt, cur_nxt;
  logic          wrap, out_nxt;

  // A written zero stands for 2**CNT_W.
  always_comb begin
    ld_ext   = (load_val == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, load_val};
    wrap     = (cur_q == EW'(1));
    n_nxt    = (wrap && pend_q) ? stage_q : n_q;
    half_nxt = (wrap && pend_q) ? (stage_q >> 1) : half_q;
    cur_nxt  = wrap ? n_nxt : cur_q - EW'(1);
    out_nxt  = (cur_nxt > half_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running_q <= 1'b0;
      pend_q    <= 1'b0;
      out_q     <= 1'b0;
      irq_q     <= 1'b0;
      n_q       <= '0;
      half_q    <= '0;
      cur_q     <= '0;
      stage_q   <= '0;
    end else if (mode_wr) begin
      running_q <= 1'b0;
      pend_q    <= 1'b0;
      out_q     <= 1'b1;
      irq_q     <= 1'b0;
    end else if (!running_q) begin
      irq_q <= 1'b0;
      if (load_stb) begin
        running_q <= 1'b1;
        n_q       <= ld_ext;
        half_q    <= ld_ext >> 1;
        cur_q     <= ld_ext;
        out_q     <= 1'b1;
      end
    end else begin
      cur_q <= cur_nxt;
      out_q <= out_nxt;
      irq_q <= out_nxt & ~out_q;
      if (wrap) begin
        n_q    <= n_nxt;
        half_q <= half_nxt;
        pend_q <= 1'b0;
      end
      if (load_stb) begin
        pend_q  <= 1'b1;
        stage_q <= ld_ext;
      end
    end
  end

  assign tmr_out = out_q;
  assign tmr_irq = irq_q;
  assign cur_cnt = cur_q[CNT_W-1:0];

  // R6: a request only accompanies a low-to-high output step
  p_irq_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (out_q && !$past(out_q)));
  // R6: the request lasts one cycle
  p_irq_single_r6: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  // R2: an idle channel raises no request
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !running_q |-> !irq_q);
  // R5: the count stays inside 1..N while running
  p_cur_range_r5: assert property (@(posedge clk) disable iff (rst)
    running_q |-> (cur_q != '0 && cur_q <= n_q));
  // R5: between boundaries the count steps down by one per cycle
  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (running_q && $past(running_q) && $past(cur_q) != EW'(1))
      |-> (cur_q == $past(cur_q) - EW'(1)));
endmodule

// File: rtl/pit_readback.sv
module pit_readback #(
  parameter int DW = 8,
  localparam int CNT_W = 2 * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wr,
  input  logic             latch_cmd,
  input  logic             rd_en,
  input  logic             rd_ctrl,
  input  logic [CNT_W-1:0] cur_cnt,
  output logic [DW-1:0]    rdata
);
  logic             latched_q, rd_hi_q;
  logic [CNT_W-1:0] lat_q, src;
  logic [DW-1:0]    rdata_q;

  assign src = latched_q ? lat_q : cur_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      latched_q <= 1'b0;
      rd_hi_q   <= 1'b0;
      lat_q     <= '0;
      rdata_q   <= '0;
    end else begin
      if (rd_en) rdata_q <= rd_ctrl ? '0 : (rd_hi_q ? src[CNT_W-1:DW] : src[DW-1:0]);
      if (mode_wr) begin
        latched_q <= 1'b0;
        rd_hi_q   <= 1'b0;
      end else if (latch_cmd && !latched_q) begin
        latched_q <= 1'b1;
        lat_q     <= cur_cnt;
        rd_hi_q   <= 1'b0;
      end else if (rd_en && !rd_ctrl) begin
        rd_hi_q <= ~rd_hi_q;
        if (rd_hi_q) latched_q <= 1'b0;
      end
    end
  end

  assign rdata = rdata_q;

  // R8: a held snapshot never changes
  p_latch_hold_r8: assert property (@(posedge clk) disable iff (rst)
    $past(latched_q) |-> $stable(lat_q));
  // R9: control-port reads return zero
  p_rd_ctrl_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && rd_ctrl) |-> (rdata_q == '0));
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CHAN_ID = 0,
  localparam int CNT_W  = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          tmr_out,
  output logic          tmr_irq
);
  logic             cw_wr, dat_wr, mode_wr, latch_cmd, load_stb;
  acc_e             acc;
  logic [CNT_W-1:0] load_val, cur_cnt;

  assign cw_wr  = bus_wr & bus_addr;
  assign dat_wr = bus_wr & ~bus_addr;

  pit_cw_decode #(.DW(DW), .CHAN_ID(CHAN_ID)) u_dec (
    .clk(clk), .rst(rst), .cw_wr(cw_wr), .wdata(bus_wdata),
    .mode_wr(mode_wr), .latch_cmd(latch_cmd), .acc(acc));

  pit_loader #(.DW(DW)) u_ld (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .acc(acc), .dat_wr(dat_wr),
    .wdata(bus_wdata), .load_stb(load_stb), .load_val(load_val));

  pit_sqwave #(.CNT_W(CNT_W)) u_sq (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .load_stb(load_stb),
    .load_val(load_val), .tmr_out(tmr_out), .tmr_irq(tmr_irq), .cur_cnt(cur_cnt));

  pit_readback #(.DW(DW)) u_rb (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .latch_cmd(latch_cmd),
    .rd_en(bus_rd), .rd_ctrl(bus_addr), .cur_cnt(cur_cnt), .rdata(bus_rdata));
endmodule

// File: tb/pit_channel_tb_top.sv
`timescale 1ns/1ps
module pit_channel_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       tmr_out, tmr_irq;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  logic rd_seen = 1'b0;
  bit done = 0;

  int    irq_q[$];
  string irq_tag[$];
  int    rd_exp[$];
  string rd_tag[$];

  always #2.5 clk = ~clk;

  pit_channel dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_out(tmr_out), .tmr_irq(tmr_irq));

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    rd_seen <= bus_rd;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: interrupt requests and read data against the scoreboard queues.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (irq_q.size() > 0 && cyc > irq_q[0] && !tmr_irq) begin
        chk(0, {irq_tag[0], " missed irq"}, cyc, irq_q[0]);
        void'(irq_q.pop_front()); void'(irq_tag.pop_front());
      end
      if (tmr_irq) begin
        if (irq_q.size() == 0) chk(0, "R6 unexpected irq", cyc, -1);
        else begin
          chk(cyc == irq_q[0], {irq_tag[0], " irq cycle"}, cyc, irq_q[0]);
          void'(irq_q.pop_front()); void'(irq_tag.pop_front());
        end
      end
      if (rd_seen) begin
        if (rd_exp.size() == 0) chk(0, "R9 unexpected read", bus_rdata, -1);
        else begin
          chk(bus_rdata == rd_exp[0][7:0], {rd_tag[0], " rdata"}, bus_rdata, rd_exp[0]);
          void'(rd_exp.pop_front()); void'(rd_tag.pop_front());
        end
      end
    end
  end

  // Write one byte; returns the edge number on which it lands.
  task automatic wr(input logic a, input logic [7:0] d, output int k);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    k = cyc + 1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, input int n, input int k, input int lat, input bit hi,
                    input string tag);
    int r, v;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    r = cyc + 1;
    if (a) v = 0;
    else if (lat >= 0) v = lat;
    else v = n - ((r - 1 - k) % n);
    rd_exp.push_back(hi ? ((v >> 8) & 255) : (v & 255));
    rd_tag.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Compare the output level with the square-wave rule for ncyc cycles.
  task automatic wave(input int k, input int n, input int ncyc, input string tag);
    int bad = 0, first_act = 0, first_exp = 0;
    for (int i = 0; i < ncyc; i++) begin
      int t;
      bit e;
      t = cyc - k;
      e = (t % n) < ((n + 1) / 2);
      if (tmr_out !== e && bad == 0) begin first_act = tmr_out; first_exp = e; end
      if (tmr_out !== e) bad++;
      @(negedge clk);
    end
    chk(bad == 0, tag, first_act, first_exp);
  endtask

  task automatic run_period(input int n, input logic [7:0] cw, input string tag);
    int k, k0;
    wr(1'b1, cw, k0);
    wr(1'b0, n[7:0], k0);
    wr(1'b0, n[15:8], k);
    for (int j = 1; j * n < 3 * n + 1; j++) begin
      irq_q.push_back(k + j * n); irq_tag.push_back(tag);
    end
    wave(k, n, 3 * n + 2, {tag, " waveform"});
    wr(1'b1, 8'h36, k0);
    idle(2);
    chk(irq_q.size() == 0, {tag, " all irqs seen"}, irq_q.size(), 0);
  endtask

  initial begin
    int k, k0, l, v;
    idle(3);
    @(negedge clk) rst = 1'b0;
    chk(tmr_out == 1'b0 && tmr_irq == 1'b0, "R1 out/irq after reset", {tmr_out, tmr_irq}, 0);
    chk(bus_rdata == 8'h00, "R1 rdata after reset", bus_rdata, 0);

    // R3: data before any mode write is ignored
    wr(1'b0, 8'h05, k0); wr(1'b0, 8'h00, k0);
    idle(12);
    chk(tmr_out == 1'b0, "R3 data ignored before mode write", tmr_out, 0);

    // R2: rejected control words
    wr(1'b1, 8'h76, k0); idle(1);
    chk(tmr_out == 1'b0, "R2 other channel ignored", tmr_out, 0);
    wr(1'b1, 8'h37, k0); idle(1);
    chk(tmr_out == 1'b0, "R2 BCD ignored", tmr_out, 0);
    wr(1'b1, 8'h32, k0); idle(1);
    chk(tmr_out == 1'b0, "R2 other mode ignored", tmr_out, 0);
    wr(1'b1, 8'h36, k0); idle(1);
    chk(tmr_out == 1'b1, "R2 mode write drives out high", tmr_out, 1);

    // R5/R6 even and odd counts, R4 low-byte-only access
    run_period(6, 8'h36, "R5 even N=6");
    run_period(7, 8'h36, "R5 odd N=7");
    wr(1'b1, 8'h16, k0);
    wr(1'b0, 8'h05, k);
    for (int j = 1; j <= 3; j++) begin irq_q.push_back(k + 5 * j); irq_tag.push_back("R4 lo-only N=5"); end
    wave(k, 5, 17, "R4 lo-only waveform");
    wr(1'b1, 8'h36, k0); idle(2);
    chk(irq_q.size() == 0, "R6 lo-only irqs seen", irq_q.size(), 0);

    // R4 high-byte-only: N=256, live readback (R9)
    wr(1'b1, 8'h26, k0);
    wr(1'b0, 8'h01, k);
    idle(3);
    rd(1'b0, 256, k, -1, 1'b0, "R9 live lo N=256");
    rd(1'b0, 256, k, -1, 1'b1, "R4 live hi N=256");
    wr(1'b1, 8'h36, k0); idle(2);

    // R8 latch
    wr(1'b0, 8'hE8, k0); wr(1'b0, 8'h03, k);
    idle(37);
    wr(1'b1, 8'h00, l);
    v = 1000 - ((l - 1 - k) % 1000);
    idle(5);
    wr(1'b1, 8'h00, k0);
    rd(1'b0, 1000, k, v, 1'b0, "R8 latched lo");
    idle(4);
    rd(1'b0, 1000, k, v, 1'b1, "R8 latched hi");
    idle(2);
    rd(1'b0, 1000, k, -1, 1'b0, "R8 released live lo");
    rd(1'b1, 1000, k, -1, 1'b0, "R9 control read zero");
    wr(1'b1, 8'h36, k0); idle(2);

    // R7 new count while running
    wr(1'b0, 8'h06, k0); wr(1'b0, 8'h00, k);
    wr(1'b0, 8'h0A, k0); wr(1'b0, 8'h00, k0);
    irq_q.push_back(k + 6);  irq_tag.push_back("R7 old period ends");
    irq_q.push_back(k + 16); irq_tag.push_back("R7 new period");
    irq_q.push_back(k + 26); irq_tag.push_back("R7 new period");
    while (cyc < k + 30) @(negedge clk);
    wr(1'b1, 8'h36, k0); idle(2);
    chk(irq_q.size() == 0, "R7 all irqs seen", irq_q.size(), 0);

    // R3 count 0 = 65536
    wr(1'b0, 8'h00, k0); wr(1'b0, 8'h00, k);
    idle(4);
    rd(1'b0, 65536, k, -1, 1'b0, "R3 zero count lo");
    rd(1'b0, 65536, k, -1, 1'b1, "R3 zero count hi");
    wr(1'b1, 8'h36, k0); idle(2);

    // R10 count 1
    wr(1'b0, 8'h01, k0); wr(1'b0, 8'h00, k);
    wave(k, 1, 12, "R10 count 1 holds high");

    idle(4);
    chk(rd_exp.size() == 0 && irq_q.size() == 0, "R9 scoreboard drained",
        rd_exp.size() + irq_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    done = 1;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule